// File: doc/BRIEF.md
# Block Cipher Chaining Controller

This block wraps an external block-cipher core with the chaining logic needed for cipher-block chaining (encrypt or decrypt) and counter mode. It takes blocks from an input FIFO, runs them through a per-word data-type swap stage and the core, and pushes results to an output FIFO. Along the way it keeps the initialization vector up to date: the last ciphertext in chained encryption, the last ciphertext input in chained decryption, or a 32-bit counter in counter mode.

The core is reached only through a start/done handshake carrying a data word and a direction bit. The block size is chosen at run time: 128 bits, or 64 bits held in the low half of every data port. Software loads the vector through a write strobe that only takes effect while the block is idle.

Top module: `chain_mode_ctrl`

## Requirements
- R1: After reset `busy`, `coreStart`, `inPop` and `outPush` are low and `ivRd` is zero.
- R2: Chained encryption (`mode`=0) sends `ivRd` XOR the swapped input block to the core. It outputs the swapped core result and loads that core result into the vector.
- R3: Chained decryption (`mode`=1) sends the swapped input block to the core and outputs the swapped value of (core result XOR vector). Only after that push does it load the swapped input block into the vector and pop the input FIFO.
- R4: Counter mode (`mode`=2 or 3) sends the vector itself to the core in the encrypt direction. It outputs the swapped value of (core result XOR swapped input block), so the same setting both encrypts and decrypts.
- R5: In counter mode, each output push adds one to bits 31:0 of the vector modulo 2^32. Bits above 31 do not change.
- R6: With `wideBlock`=0 the block is 64 bits. Bits 127:64 of `coreDin` and `outData` are zero, and a vector write keeps only bits 63:0.
- R7: A vector write (`ivWrEn`) is taken only while `busy` is low. While `busy` is high the write is ignored and the vector keeps its value.
- R8: `swapSel` acts on each 32-bit word, on both input and output: 0 leaves it as is, 1 exchanges its two 16-bit halves, 2 reverses its byte order, 3 reverses its bit order.
- R9: `busy` rises on the cycle after an idle block sees a non-empty input FIFO. It falls on the cycle after the last output push that leaves the input FIFO empty.
- R10: `coreStart` is a one-cycle pulse, issued once per block. `coreDecrypt` is high at start only for `mode`=1.
- R11: `outPush` never rises while `outFull` is high, and `inPop` never rises while `inEmpty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 chained encrypt, 1 chained decrypt, 2/3 counter |
| wideBlock | input | 1 | 1 for a 128-bit block, 0 for a 64-bit block |
| swapSel | input | 2 | Per-word data-type swap selector |
| ivWrEn | input | 1 | Vector write strobe |
| ivWrData | input | 128 | Vector write value |
| ivRd | output | 128 | Current vector |
| inData | input | 128 | Head of input FIFO |
| inEmpty | input | 1 | Input FIFO empty |
| inPop | output | 1 | Pop input FIFO |
| outData | output | 128 | Block for output FIFO |
| outFull | input | 1 | Output FIFO full |
| outPush | output | 1 | Push to output FIFO |
| coreStart | output | 1 | Cipher core start pulse |
| coreDecrypt | output | 1 | Core direction, 1 for decrypt |
| coreDin | output | 128 | Core input block |
| coreDone | input | 1 | Core result valid pulse |
| coreDout | input | 128 | Core result |
| busy | output | 1 | Block is processing |

## Verification
The assertions assume that the core raises `coreDone` only once per `coreStart`, and only after it. They also assume that `mode`, `wideBlock` and `swapSel` stay still while `busy` is high, and that the input FIFO head does not change unless it is popped. The bench's core model answers each start exactly once after a set latency, and its FIFO models change the head only on a pop. The bench changes the configuration only between streams, once `busy` is low.

// File: rtl/chain_pkg.sv
package chain_pkg;
  localparam logic [1:0] MODE_CBC_ENC = 2'd0;
  localparam logic [1:0] MODE_CBC_DEC = 2'd1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FIRE, ST_WAIT, ST_PUSH, ST_REFRESH, ST_GAP
  } ctl_state_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic fire;      // core start
    logic takeCore;  // capture core result
    logic popIn;     // pop input FIFO
    logic push;      // push output FIFO
    logic bump;      // counter increment
    logic refresh;   // load vector from input head
  } strobe_t;
endpackage

// File: rtl/word_swap.sv
module word_swap #(
  parameter int WIDTH  = 128,
  parameter int WORD_W = 32
) (
  input  logic [1:0]       sel,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int NWORDS = WIDTH / WORD_W;
  localparam int HALF_W = WORD_W / 2;
  localparam int NBYTES = WORD_W / 8;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [WORD_W-1:0] wIn, wOut;
    assign wIn = din[w*WORD_W +: WORD_W];
    always_comb begin
      wOut = wIn;
      case (sel)
        2'd1: wOut = {wIn[HALF_W-1:0], wIn[WORD_W-1:HALF_W]};
        2'd2: for (int b = 0; b < NBYTES; b++)
                wOut[b*8 +: 8] = wIn[(NBYTES-1-b)*8 +: 8];
        2'd3: for (int i = 0; i < WORD_W; i++)
                wOut[i] = wIn[WORD_W-1-i];
        default: wOut = wIn;
      endcase
    end
    assign dout[w*WORD_W +: WORD_W] = wOut;
  end
endmodule

// File: rtl/chain_ctrl.sv
module chain_ctrl
  import chain_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] mode,
  input  logic       inEmpty,
  input  logic       outFull,
  input  logic       coreDone,
  output strobe_t    strb,
  output logic       busy,
  output logic       coreDecrypt
);
  ctl_state_e state, nextState;
  logic isEnc, isDec, isCtr;

  assign isEnc = (mode == MODE_CBC_ENC);
  assign isDec = (mode == MODE_CBC_DEC);
  assign isCtr = mode[1];
  assign coreDecrypt = isDec;
  assign busy = (state != ST_IDLE);

  always_comb begin
    strb = '0;
    nextState = state;
    case (state)
      ST_IDLE: if (!inEmpty) nextState = ST_FIRE;
      ST_FIRE: if (!inEmpty) begin
        strb.fire  = 1'b1;
        strb.popIn = isEnc;
        nextState  = ST_WAIT;
      end
      ST_WAIT: if (coreDone) begin
        strb.takeCore = 1'b1;
        strb.popIn    = isCtr;
        nextState     = ST_PUSH;
      end
      ST_PUSH: if (!outFull) begin
        strb.push = 1'b1;
        strb.bump = isCtr;
        if (isDec)        nextState = ST_REFRESH;
        else if (inEmpty) nextState = ST_IDLE;
        else              nextState = ST_FIRE;
      end
      ST_REFRESH: if (!inEmpty) begin
        strb.refresh = 1'b1;
        strb.popIn   = 1'b1;
        nextState    = ST_GAP;
      end
      ST_GAP: nextState = inEmpty ? ST_IDLE : ST_FIRE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/chain_datapath.sv
module chain_datapath
  import chain_pkg::*;
#(
  parameter int BLK_MAX = 128,
  parameter int CTR_W   = 32,
  parameter int WORD_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         mode,
  input  logic               wideBlock,
  input  logic [1:0]         swapSel,
  input  logic               busy,
  input  strobe_t            strb,
  input  logic               ivWrEn,
  input  logic [BLK_MAX-1:0] ivWrData,
  input  logic [BLK_MAX-1:0] inData,
  input  logic [BLK_MAX-1:0] coreDout,
  output logic [BLK_MAX-1:0] ivQ,
  output logic [BLK_MAX-1:0] coreDin,
  output logic [BLK_MAX-1:0] outData
);
  localparam int HALF = BLK_MAX / 2;

  logic [BLK_MAX-1:0] blkMask, swInRaw, swIn, resQ, swOutRaw, nextRes;
  logic isEnc, isDec, isCtr;

  assign isEnc = (mode == MODE_CBC_ENC);
  assign isDec = (mode == MODE_CBC_DEC);
  assign isCtr = mode[1];
  assign blkMask = wideBlock ? {BLK_MAX{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};

  word_swap #(.WIDTH(BLK_MAX), .WORD_W(WORD_W)) u_swIn (
    .sel(swapSel), .din(inData), .dout(swInRaw));
  word_swap #(.WIDTH(BLK_MAX), .WORD_W(WORD_W)) u_swOut (
    .sel(swapSel), .din(resQ), .dout(swOutRaw));

  assign swIn = swInRaw & blkMask;
  assign outData = swOutRaw & blkMask;

  always_comb begin
    if (isCtr)      coreDin = ivQ & blkMask;
    else if (isEnc) coreDin = (ivQ ^ swIn) & blkMask;
    else            coreDin = swIn;
  end

  always_comb begin
    if (isDec)      nextRes = (coreDout ^ ivQ) & blkMask;
    else if (isCtr) nextRes = (coreDout ^ swIn) & blkMask;
    else            nextRes = coreDout & blkMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ivQ  <= '0;
      resQ <= '0;
    end else begin
      if (strb.takeCore) resQ <= nextRes;
      if (strb.takeCore && isEnc)
        ivQ <= coreDout & blkMask;
      else if (strb.refresh)
        ivQ <= swIn;
      else if (strb.bump)
        ivQ <= {ivQ[BLK_MAX-1:CTR_W], ivQ[CTR_W-1:0] + CTR_W'(1)};
      else if (!busy && ivWrEn)
        ivQ <= ivWrData & blkMask;
    end
  end
endmodule

// File: rtl/chain_mode_ctrl.sv
module chain_mode_ctrl
  import chain_pkg::*;
#(
  parameter int BLK_MAX = 128,
  parameter int CTR_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         mode,
  input  logic               wideBlock,
  input  logic [1:0]         swapSel,
  input  logic               ivWrEn,
  input  logic [BLK_MAX-1:0] ivWrData,
  output logic [BLK_MAX-1:0] ivRd,
  input  logic [BLK_MAX-1:0] inData,
  input  logic               inEmpty,
  output logic               inPop,
  output logic [BLK_MAX-1:0] outData,
  input  logic               outFull,
  output logic               outPush,
  output logic               coreStart,
  output logic               coreDecrypt,
  output logic [BLK_MAX-1:0] coreDin,
  input  logic               coreDone,
  input  logic [BLK_MAX-1:0] coreDout,
  output logic               busy
);
  strobe_t strb;

  chain_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode), .inEmpty(inEmpty),
    .outFull(outFull), .coreDone(coreDone), .strb(strb),
    .busy(busy), .coreDecrypt(coreDecrypt));

  chain_datapath #(.BLK_MAX(BLK_MAX), .CTR_W(CTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .mode(mode), .wideBlock(wideBlock),
    .swapSel(swapSel), .busy(busy), .strb(strb), .ivWrEn(ivWrEn),
    .ivWrData(ivWrData), .inData(inData), .coreDout(coreDout),
    .ivQ(ivRd), .coreDin(coreDin), .outData(outData));

  assign coreStart = strb.fire;
  assign inPop     = strb.popIn;
  assign outPush   = strb.push;
endmodule

// File: rtl/chain_mode_ctrl_checker.sv
module chain_mode_ctrl_checker (
  input logic         clk,
  input logic         rstN,
  input logic [1:0]   mode,
  input logic         wideBlock,
  input logic         ivWrEn,
  input logic [127:0] ivRd,
  input logic         inEmpty,
  input logic         inPop,
  input logic [127:0] outData,
  input logic         outFull,
  input logic         outPush,
  input logic         coreStart,
  input logic         coreDecrypt,
  input logic [127:0] coreDin,
  input logic         coreDone,
  input logic [127:0] coreDout,
  input logic         busy
);
  assert_chain_enc_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && mode == 2'd0 && coreDone) |=>
      ivRd == ($past(wideBlock) ? $past(coreDout) : {64'b0, $past(coreDout[63:0])}));

  assert_ctr_core_in_R4: assert property (@(posedge clk) disable iff (!rstN)
    (coreStart && mode[1]) |-> coreDin == ivRd);

  assert_ctr_bump_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outPush && mode[1]) |=>
      (ivRd[31:0] == $past(ivRd[31:0]) + 32'd1) && (ivRd[127:32] == $past(ivRd[127:32])));

  assert_narrow_upper_R6: assert property (@(posedge clk) disable iff (!rstN)
    !wideBlock |-> (coreDin[127:64] == 64'b0) && (outData[127:64] == 64'b0));

  assert_iv_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !ivWrEn) |=> $stable(ivRd));

  assert_busy_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !inEmpty) |=> busy);

  assert_busy_fall_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outPush && inEmpty && mode != 2'd1) |=> !busy);

  assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    coreStart |=> !coreStart);

  assert_direction_R10: assert property (@(posedge clk) disable iff (!rstN)
    coreStart |-> (coreDecrypt == (mode == 2'd1)) && busy);

  assert_no_push_full_R11: assert property (@(posedge clk) disable iff (!rstN)
    outFull |-> !outPush);

  assert_no_pop_empty_R11: assert property (@(posedge clk) disable iff (!rstN)
    inEmpty |-> !inPop);
endmodule

bind chain_mode_ctrl chain_mode_ctrl_checker u_chk (.*);

// File: tb/sim_chain_mode_ctrl.sv
module sim_chain_mode_ctrl;
  localparam int LIMIT = 150000;
  localparam logic [127:0] KEY = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;

  typedef struct packed {
    logic [1:0] md;
    logic       wd;
    logic [1:0] sw;
    logic [3:0] n;
    logic [3:0] lat;
    logic       st;
  } row_t;

  // mode, wide, swap, blocks, core latency, output stall
  localparam row_t ROWS [8] = '{
    '{2'd0, 1'b1, 2'd0, 4'd3, 4'd2, 1'b0},
    '{2'd0, 1'b0, 2'd2, 4'd3, 4'd0, 1'b1},
    '{2'd1, 1'b1, 2'd1, 4'd4, 4'd3, 1'b0},
    '{2'd1, 1'b0, 2'd3, 4'd2, 4'd1, 1'b1},
    '{2'd2, 1'b1, 2'd3, 4'd4, 4'd1, 1'b1},
    '{2'd2, 1'b0, 2'd0, 4'd3, 4'd4, 1'b0},
    '{2'd3, 1'b1, 2'd2, 4'd2, 4'd0, 1'b0},
    '{2'd1, 1'b1, 2'd0, 4'd1, 4'd0, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] mode = 2'd0;
  logic wideBlock = 1'b1;
  logic [1:0] swapSel = 2'd0;
  logic ivWrEn = 1'b0;
  logic [127:0] ivWrData = '0;
  logic [127:0] ivRd, inData, outData, coreDin;
  logic [127:0] coreDout = '0;
  logic inEmpty, inPop, outFull, outPush, coreStart, coreDecrypt, busy;
  logic coreDone = 1'b0;

  int nChk = 0, nFail = 0, cyc = 0;
  int inRd = 0, inWr = 0, outCnt = 0, startCnt = 0;
  int pushWhileFull = 0, popWhileEmpty = 0, dirBad = 0;
  int coreLat = 0;
  bit stallEn = 1'b0;
  logic [127:0] inMem [16];
  logic [127:0] outMem [64];
  logic [127:0] pendIn = '0;
  logic pendDec = 1'b0, pend = 1'b0;
  int pendCnt = 0;

  always #4 clk = ~clk;

  chain_mode_ctrl u0 (
    .clk(clk), .rstN(rstN), .mode(mode), .wideBlock(wideBlock),
    .swapSel(swapSel), .ivWrEn(ivWrEn), .ivWrData(ivWrData), .ivRd(ivRd),
    .inData(inData), .inEmpty(inEmpty), .inPop(inPop), .outData(outData),
    .outFull(outFull), .outPush(outPush), .coreStart(coreStart),
    .coreDecrypt(coreDecrypt), .coreDin(coreDin), .coreDone(coreDone),
    .coreDout(coreDout), .busy(busy));

  function automatic logic [127:0] encf(input logic [127:0] x, input bit wd);
    logic [63:0] y;
    if (wd) return {x[119:0], x[127:120]} ^ KEY;
    y = {x[55:0], x[63:56]} ^ KEY[63:0];
    return {64'b0, y};
  endfunction

  function automatic logic [127:0] decf(input logic [127:0] x, input bit wd);
    logic [127:0] y;
    logic [63:0] z;
    if (wd) begin
      y = x ^ KEY;
      return {y[7:0], y[127:8]};
    end
    z = x[63:0] ^ KEY[63:0];
    return {64'b0, z[7:0], z[63:8]};
  endfunction

  function automatic logic [127:0] swapf(input logic [127:0] x, input logic [1:0] s);
    logic [127:0] r;
    for (int w = 0; w < 4; w++) begin
      logic [31:0] a, b;
      a = x[w*32 +: 32];
      case (s)
        2'd1: b = {a[15:0], a[31:16]};
        2'd2: b = {a[7:0], a[15:8], a[23:16], a[31:24]};
        2'd3: for (int i = 0; i < 32; i++) b[i] = a[31-i];
        default: b = a;
      endcase
      r[w*32 +: 32] = b;
    end
    return r;
  endfunction

  function automatic logic [127:0] gen(input int k);
    logic [31:0] q;
    q = k;
    return {q * 32'h9E3779B9, q * 32'h85EBCA6B, q * 32'hC2B2AE35, q * 32'h27D4EB2F};
  endfunction

  assign inEmpty = (inRd == inWr);
  assign inData  = inMem[inRd % 16];
  assign outFull = stallEn && ((cyc % 4) >= 2);

  // FIFO, output capture and core model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (inPop) begin
      if (inEmpty) popWhileEmpty <= popWhileEmpty + 1;
      inRd <= inRd + 1;
    end
    if (outPush) begin
      if (outFull) pushWhileFull <= pushWhileFull + 1;
      outMem[outCnt % 64] <= outData;
      outCnt <= outCnt + 1;
    end
    coreDone <= 1'b0;
    if (coreStart) begin
      startCnt <= startCnt + 1;
      if (coreDecrypt != (mode == 2'd1)) dirBad <= dirBad + 1;
      pend <= 1'b1;
      pendCnt <= coreLat;
      pendIn <= coreDin;
      pendDec <= coreDecrypt;
    end else if (pend) begin
      if (pendCnt == 0) begin
        coreDone <= 1'b1;
        coreDout <= pendDec ? decf(pendIn, wideBlock) : encf(pendIn, wideBlock);
        pend <= 1'b0;
      end else pendCnt <= pendCnt - 1;
    end
    if (cyc == LIMIT) begin
      $display("FAIL watchdog act=%0d exp<%0d", cyc, LIMIT);
      $display("%0d/%0d checks passed", nChk - nFail, nChk + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic runStream(input logic [1:0] md, input bit wd, input logic [1:0] sw,
                           input int n, input int lat, input bit st,
                           input logic [127:0] ivInit, input int seed,
                           input bit poke, input string tag);
    logic [127:0] mask, iv, x, t;
    logic [127:0] expOut [16];
    int outBase, startBase;
    mask = wd ? '1 : {64'b0, {64{1'b1}}};
    @(negedge clk);
    mode = md; wideBlock = wd; swapSel = sw; coreLat = lat; stallEn = st;
    ivWrEn = 1'b1; ivWrData = ivInit;
    @(negedge clk);
    ivWrEn = 1'b0;
    iv = ivInit & mask;
    for (int j = 0; j < n; j++) begin
      inMem[(inWr + j) % 16] = gen(seed + j);
      x = swapf(gen(seed + j), sw) & mask;
      if (md == 2'd0) begin
        t = encf(iv ^ x, wd);
        expOut[j] = swapf(t, sw) & mask;
        iv = t;
      end else if (md == 2'd1) begin
        t = decf(x, wd) ^ iv;
        expOut[j] = swapf(t, sw) & mask;
        iv = x;
      end else begin
        t = encf(iv, wd) ^ x;
        expOut[j] = swapf(t, sw) & mask;
        iv[31:0] = iv[31:0] + 32'd1;
      end
    end
    outBase = outCnt;
    startBase = startCnt;
    check(busy == 1'b0, {tag, " R9 idle before data"}, 128'(busy), 128'd0);
    inWr = inWr + n;
    @(negedge clk);
    check(busy == 1'b1, {tag, " R9 busy after data"}, 128'(busy), 128'd1);
    if (poke) begin
      ivWrEn = 1'b1; ivWrData = '1;
      @(negedge clk);
      ivWrEn = 1'b0;
    end
    for (int g = 0; g < 3000 && busy; g++) @(negedge clk);
    check(outCnt - outBase == n, {tag, " R11 output count"}, 128'(outCnt - outBase), 128'(n));
    check(startCnt - startBase == n, {tag, " R10 one start per block"},
          128'(startCnt - startBase), 128'(n));
    for (int j = 0; j < n; j++)
      check(outMem[(outBase + j) % 64] == expOut[j], {tag, " R8 output block"},
            outMem[(outBase + j) % 64], expOut[j]);
    check(ivRd == iv, {tag, " final vector"}, ivRd, iv);
    stallEn = 1'b0;
  endtask

  initial begin
    string tg;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1 busy", 128'(busy), 128'd0);
    check(ivRd == '0, "R1 vector", ivRd, 128'd0);
    check(coreStart == 1'b0, "R1 coreStart", 128'(coreStart), 128'd0);
    check(outPush == 1'b0, "R1 outPush", 128'(outPush), 128'd0);
    check(inPop == 1'b0, "R1 inPop", 128'(inPop), 128'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int r = 0; r < 8; r++) begin
      case (ROWS[r].md)
        2'd0: tg = "R2 chained encrypt";
        2'd1: tg = "R3 chained decrypt";
        default: tg = "R4 R5 counter";
      endcase
      runStream(ROWS[r].md, ROWS[r].wd, ROWS[r].sw, int'(ROWS[r].n), int'(ROWS[r].lat),
                ROWS[r].st, gen(r * 37 + 500), r * 16 + 1, 1'b0, tg);
    end

    // R5: counter wraps in the low word, upper bits kept
    runStream(2'd2, 1'b1, 2'd1, 2, 1, 1'b0,
              {96'hA5A5_0123_4567_89AB_CDEF_1357, 32'hFFFF_FFFF}, 300, 1'b0, "R5 wrap");
    check(ivRd == {96'hA5A5_0123_4567_89AB_CDEF_1357, 32'h0000_0001}, "R5 wrap value",
          ivRd, {96'hA5A5_0123_4567_89AB_CDEF_1357, 32'h0000_0001});

    // R7: write while busy is ignored (model keeps the chained value)
    runStream(2'd0, 1'b1, 2'd0, 2, 10, 1'b0, gen(900), 400, 1'b1, "R7 busy write");
    runStream(2'd1, 1'b1, 2'd2, 1, 12, 1'b0, gen(901), 410, 1'b1, "R7 busy write dec");

    // R6 and R7: idle write is taken and trimmed to 64 bits
    @(negedge clk);
    wideBlock = 1'b0; ivWrEn = 1'b1; ivWrData = '1;
    @(negedge clk);
    ivWrEn = 1'b0;
    check(ivRd == {64'b0, {64{1'b1}}}, "R6 R7 idle narrow write", ivRd, {64'b0, {64{1'b1}}});
    wideBlock = 1'b1; ivWrEn = 1'b1; ivWrData = gen(77);
    @(negedge clk);
    ivWrEn = 1'b0;
    check(ivRd == gen(77), "R7 idle wide write", ivRd, gen(77));

    check(pushWhileFull == 0, "R11 push while full", 128'(pushWhileFull), 128'd0);
    check(popWhileEmpty == 0, "R11 pop while empty", 128'(popWhileEmpty), 128'd0);
    check(dirBad == 0, "R10 core direction", 128'(dirBad), 128'd0);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule